// File: doc/BRIEF.md
# Level-Sensed GPIO Block with Interrupt Aggregation

This block drives up to 32 general-purpose pads and watches them for interrupt conditions. Each line can be set as an input or an output. Output lines drive a stored value onto the pad and enable the pad driver. Input lines are passed through a synchroniser. The synchronised value is read back through the data register and also feeds a level detector. The detector's polarity is chosen per line.

When a line sits at its active level, its status bit becomes set. The bit stays set until software clears it by writing a 0 to that bit position. A second register window exposes the raw status as a pending view, together with a per-line mask. The single interrupt request output is raised whenever any unmasked status bit is set.

Software reaches both windows over a simple register port. A window-select input picks the window, and a byte offset picks the register. Every access is a full 32-bit word completed in one clock cycle. Read data is combinational from the stored state.

Top module: `lvlgpio_top`

## Requirements
- R1: After reset: direction reads 0 (all lines inputs, `pin_oe` low), data output reads 0, polarity reads all ones, status reads 0, mask reads all ones, and `irq_out` is low.
- R2: The GPIO window offset 0x00 holds the direction register; bit 1 makes that line an output and is driven on `pin_oe`. Offset 0x04 stores the output value, driven on `pin_out`. The pad outputs change only when their register is written.
- R3: A read of GPIO offset 0x04 returns the stored output value for output lines. For input lines it returns `pin_in` after the synchroniser, which reflects a pad change after two rising clock edges.
- R4: GPIO offset 0x08 selects each line's active level: 1 means active-high, 0 means active-low. A status bit becomes set on the clock edge after the synchronised pin shows the active level. A pad change is therefore visible in status after three rising edges.
- R5: A write to GPIO offset 0x0C clears every status bit written as 0 and leaves every bit written as 1 unchanged. Writing the inverse of a one-hot value acknowledges exactly one line.
- R6: If a line is still at its active level when its status bit is cleared, the bit sets again on the next clock edge.
- R7: Status bits are sticky: they stay set after the line leaves its active level, until they are cleared by a write.
- R8: The interrupt window offset 0x00 reads the status without the mask applied. Writes to this offset have no effect.
- R9: Interrupt window offset 0x08 is the mask register, where a 1 blocks the line. `irq_out` is the OR over all lines of status AND NOT mask.
- R10: Offsets 0x04 and 0x0C of the interrupt window, and any byte address whose two low bits are not zero, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_win | input | 1 | Window select: 0 = GPIO window, 1 = interrupt window |
| reg_addr | input | 4 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | NUM_LINES | Pad input values, asynchronous |
| pin_oe | output | NUM_LINES | Pad output enables (the direction register) |
| pin_out | output | NUM_LINES | Pad output values |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: NUM_LINES = 32 and SYNC_STAGES = 2. With these values every bit of each 32-bit register maps to a real line, so random register words cover all lines, including the top bit.

The two-stage synchroniser fixes the latency at three edges from a pad change to status. The directed tests check status one edge before and exactly at that point. They also check the clear-and-reset-next-cycle behaviour while a line is held active.

// File: rtl/lvlgpio_pkg.sv
package lvlgpio_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        WIN_GPIO = 1'b0,
        WIN_IRQ  = 1'b1
    } win_e;

    // word index (byte offset >> 2) inside each window
    localparam logic [1:0] IDX_DIR  = 2'd0;
    localparam logic [1:0] IDX_DATA = 2'd1;
    localparam logic [1:0] IDX_POL  = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;
    localparam logic [1:0] IDX_PEND = 2'd0;
    localparam logic [1:0] IDX_MASK = 2'd2;

endpackage

// File: rtl/lvlgpio_sync.sv
module lvlgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lvlgpio_cfg.sv
module lvlgpio_cfg #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_dout,
    input  logic             wr_pol,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dir,
    output logic [LINES-1:0] dout,
    output logic [LINES-1:0] pol
);

    typedef struct packed {
        logic [LINES-1:0] dir;
        logic [LINES-1:0] dout;
        logic [LINES-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_dir)  cfg_d.dir  = wdata;
        if (wr_dout) cfg_d.dout = wdata;
        if (wr_pol)  cfg_d.pol  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dir  <= '0;
            cfg_q.dout <= '0;
            cfg_q.pol  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir  = cfg_q.dir;
    assign dout = cfg_q.dout;
    assign pol  = cfg_q.pol;

    // R2: the direction only moves when it is written
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir));

endmodule

// File: rtl/lvlgpio_irq.sv
module lvlgpio_irq #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_in,
    input  logic [LINES-1:0] pol,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] status,
    output logic [LINES-1:0] mask,
    output logic             irq
);

    typedef struct packed {
        logic [LINES-1:0] status;
        logic [LINES-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [LINES-1:0] active;

    always_comb begin
        active = ~(lvl_in ^ pol);
        st_d   = st_q;
        if (wr_stat) begin
            st_d.status = st_q.status & wdata;
        end else begin
            st_d.status = st_q.status | active;
        end
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;
    assign irq    = |(st_q.status & ~st_q.mask);

    // R5: after a status write, every bit written as 0 is clear
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status & ~$past(wdata)) == '0));

    // R7: without a status write, no bit ever falls
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((status & $past(status)) == $past(status)));

    // R4: a bit only sets if its line was active in the previous cycle
    assert_set_needs_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(active)) == '0));

endmodule

// File: rtl/lvlgpio_top.sv
module lvlgpio_top #(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic                 reg_win,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [NUM_LINES-1:0] pin_out,
    output logic                 irq_out
);
    import lvlgpio_pkg::*;

    logic [NUM_LINES-1:0] pin_sync, dir, dout, pol, status, mask, wline;
    logic       aligned, wr_any, gpio_sel, irq_sel;
    logic [1:0] idx;
    logic       wr_dir, wr_dout, wr_pol, wr_stat, wr_mask;
    word_t      rd_word;

    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign idx      = reg_addr[3:2];
    assign gpio_sel = aligned && (win_e'(reg_win) == WIN_GPIO);
    assign irq_sel  = aligned && (win_e'(reg_win) == WIN_IRQ);
    assign wr_any   = reg_en && reg_we;
    assign wr_dir   = wr_any && gpio_sel && (idx == IDX_DIR);
    assign wr_dout  = wr_any && gpio_sel && (idx == IDX_DATA);
    assign wr_pol   = wr_any && gpio_sel && (idx == IDX_POL);
    assign wr_stat  = wr_any && gpio_sel && (idx == IDX_STAT);
    assign wr_mask  = wr_any && irq_sel  && (idx == IDX_MASK);
    assign wline    = reg_wdata[NUM_LINES-1:0];

    lvlgpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync));

    lvlgpio_cfg #(.LINES(NUM_LINES)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_dout(wr_dout),
        .wr_pol(wr_pol), .wdata(wline), .dir(dir), .dout(dout), .pol(pol));

    lvlgpio_irq #(.LINES(NUM_LINES)) irq_i (
        .clk(clk), .rst_n(rst_n), .lvl_in(pin_sync), .pol(pol),
        .wr_stat(wr_stat), .wr_mask(wr_mask), .wdata(wline),
        .status(status), .mask(mask), .irq(irq_out));

    always_comb begin
        rd_word = '0;
        if (gpio_sel) begin
            case (idx)
                IDX_DIR:  rd_word[NUM_LINES-1:0] = dir;
                IDX_DATA: rd_word[NUM_LINES-1:0] = (dir & dout) | (~dir & pin_sync);
                IDX_POL:  rd_word[NUM_LINES-1:0] = pol;
                default:  rd_word[NUM_LINES-1:0] = status;
            endcase
        end else if (irq_sel) begin
            if (idx == IDX_PEND)      rd_word[NUM_LINES-1:0] = status;
            else if (idx == IDX_MASK) rd_word[NUM_LINES-1:0] = mask;
        end
    end

    assign reg_rdata = rd_word;
    assign pin_oe    = dir;
    assign pin_out   = dout;

    // R9: with every line masked the request stays low
    assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_out);

    // R2: the output value only moves when the data register is written
    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dout |=> $stable(pin_out));

endmodule

// File: tb/lvlgpio_top_tb_top.sv
`timescale 1ns/1ps
module lvlgpio_top_tb_top;
    localparam int N = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, reg_en, reg_we, reg_win, irq_out;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [N-1:0] pin_in, pin_oe, pin_out;

    lvlgpio_top #(.NUM_LINES(N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_win(reg_win), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .irq_out(irq_out));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_dir, m_dout, m_pol, m_mask, m_stat, rv;

    function automatic logic [31:0] act(logic [31:0] p, logic [31:0] pl);
        return ~(p ^ pl);
    endfunction
    function automatic logic [31:0] exp_data(logic [31:0] d, logic [31:0] o, logic [31:0] p);
        return (d & o) | (~d & p);
    endfunction

    task automatic check(string req, logic [31:0] a, logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic wr(logic w, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_win = w; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(logic w, logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_win = w; reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] old_p, np, w;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; reg_en = 0; reg_we = 0; reg_win = 0; reg_addr = 0;
        reg_wdata = 0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        rd(0, 4'h0, rv); check("R1 dir", rv, 32'h0);
        rd(0, 4'h4, rv); check("R1 data", rv, 32'h0);
        rd(0, 4'h8, rv); check("R1 pol", rv, 32'hFFFF_FFFF);
        rd(0, 4'hC, rv); check("R1 stat", rv, 32'h0);
        rd(1, 4'h8, rv); check("R1 mask", rv, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        check("R1 oe", pin_oe, 32'h0);

        // R4 latency, active-high line 0
        wr(1, 4'h8, 32'hFFFF_FFFE);
        @(negedge clk) pin_in = 32'h1;
        @(posedge clk); @(posedge clk);
        rd(0, 4'hC, rv); check("R4 stat before third edge", rv, 32'h0);
        @(posedge clk);
        rd(0, 4'hC, rv); check("R4 stat at third edge", rv, 32'h1);
        check("R9 irq unmasked", {31'b0, irq_out}, 32'h1);
        // R5/R6 clear while active, re-sets next edge
        wr(0, 4'hC, 32'hFFFF_FFFE);
        rd(0, 4'hC, rv); check("R5 cleared", rv, 32'h0);
        check("R9 irq after clear", {31'b0, irq_out}, 32'h0);
        @(posedge clk);
        rd(0, 4'hC, rv); check("R6 re-set", rv, 32'h1);
        // R7 sticky after level leaves
        @(negedge clk) pin_in = 32'h0;
        repeat (4) @(posedge clk);
        rd(1, 4'h0, rv); check("R7 sticky pend", rv, 32'h1);
        wr(0, 4'hC, 32'h0);
        repeat (3) @(posedge clk);
        rd(0, 4'hC, rv); check("R7 stays clear", rv, 32'h0);
        // R4 active-low line 1 while masked
        wr(0, 4'h8, 32'hFFFF_FFFD);
        wr(1, 4'h8, 32'hFFFF_FFFF);
        @(posedge clk);
        rd(1, 4'h0, rv); check("R8 pend unmasked view", rv, 32'h2);
        check("R9 masked irq", {31'b0, irq_out}, 32'h0);
        // R8 write to pending ignored
        wr(1, 4'h0, 32'h0);
        rd(1, 4'h0, rv); check("R8 pend write ignored", rv, 32'h2);
        // R10 unmapped and misaligned
        wr(1, 4'h4, 32'h1234_5678);
        rd(1, 4'h4, rv); check("R10 irq 0x04 zero", rv, 32'h0);
        rd(1, 4'hC, rv); check("R10 irq 0x0C zero", rv, 32'h0);
        rd(1, 4'h8, rv); check("R10 mask untouched", rv, 32'hFFFF_FFFF);
        wr(0, 4'h1, 32'hFFFF_FFFF);
        check("R10 misaligned write", pin_oe, 32'h0);
        rd(0, 4'h2, rv); check("R10 misaligned read", rv, 32'h0);
        // R2 outputs
        wr(0, 4'h0, 32'hA5A5_0F0F);
        wr(0, 4'h4, 32'h3C3C_FFFF);
        check("R2 oe", pin_oe, 32'hA5A5_0F0F);
        check("R2 out", pin_out, 32'h3C3C_FFFF);

        // return to a known state for the random phase
        wr(0, 4'h8, 32'hFFFF_FFFF);
        repeat (3) @(posedge clk);
        wr(0, 4'hC, 32'h0);
        m_pol = 32'hFFFF_FFFF; m_mask = 32'hFFFF_FFFF; m_stat = 0;
        m_dir = 32'hA5A5_0F0F; m_dout = 32'h3C3C_FFFF;

        for (int it = 0; it < 60; it++) begin
            m_dir = $urandom; wr(0, 4'h0, m_dir);
            m_dout = $urandom; wr(0, 4'h4, m_dout);
            m_mask = $urandom | $urandom; wr(1, 4'h8, m_mask);
            np = $urandom; old_p = pin_in;
            wr(0, 4'h8, np); m_pol = np;
            m_stat |= act(old_p, np);
            @(negedge clk) pin_in = $urandom;
            repeat (4) @(posedge clk);
            m_stat |= act(pin_in, np);
            rd(0, 4'h4, rv); check("R3 data readback", rv, exp_data(m_dir, m_dout, pin_in));
            check("R2 oe random", pin_oe, m_dir);
            check("R2 out random", pin_out, m_dout);
            rd(1, 4'h0, rv); check("R8 pend random", rv, m_stat);
            rd(0, 4'hC, rv); check("R4 stat random", rv, m_stat);
            check("R9 irq random", {31'b0, irq_out}, {31'b0, |(m_stat & ~m_mask)});
            w = (it % 3 == 0) ? ~(32'h1 << (it % 32)) : $urandom;
            wr(0, 4'hC, w);
            m_stat = (m_stat & w) | act(pin_in, np);
            repeat (2) @(posedge clk);
            rd(0, 4'hC, rv); check("R5 stat after clear", rv, m_stat);
            check("R9 irq after clear", {31'b0, irq_out}, {31'b0, |(m_stat & ~m_mask)});
        end

        done = 1;
        summary();
        $finish;
    end
endmodule